// File: doc/BRIEF.md
# LPC Host Interrupt Request Controller

This block drives the level-sensitive host interrupt request lines that a peripheral-side LPC interface hands to its serialized-IRQ encoder. It tracks four LPC channels. Each channel holds an output-buffer-full flag and a word of per-kind host interrupt enables. Firmware sets the flag by loading the channel's output data register, or the final byte of its two-way buffer. A host read of either one empties the flag.

One global mode input decides what removes a request. In linked mode (`direct_mode` = 0), a request needs both its enable and a full output buffer. When a host read empties the buffer, all of that channel's enables clear themselves, so the request falls with no firmware action. In direct mode (`direct_mode` = 1), the enables alone drive the requests, and only a firmware write that clears an enable removes a request. Each output line is the OR over every channel that may raise that interrupt kind.

Top module: `lpc_hirq_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears every output-buffer-full flag and every enable, so `obf` and `irq_req` read all zeros after that edge.
- R2: A pulse on `odr_fw_wr[c]` sets `obf[c]` at the next edge, and a pulse on `odr_host_rd[c]` clears it. When both pulse in the same cycle, the flag ends up set.
- R3: The kind bit positions in `en_wdata` and `irq_req` are: bit 0 SMI, bit 1 IRQ1, bit 2 IRQ6, bit 3 IRQ9, bit 4 IRQ10, bit 5 IRQ11, bit 6 IRQ12. Channel index 0 stores only bits 1 and 6. Channel indices 1 to 3 store only bits 0, 2, 3, 4 and 5. An enable write replaces the channel's whole enable word, and any disallowed bits in it are dropped.
- R4: In linked mode, `irq_req[k]` is 1 exactly when some channel has enable k set and its `obf` set. With every flag empty, no request is raised.
- R5: In linked mode, a host read of channel c while `obf[c]` is 1 clears all enables of channel c at that edge. A host read while `obf[c]` is already 0 leaves the enables unchanged.
- R6: In linked mode, when a host read that empties channel c and an enable write to channel c happen in the same cycle, the enables of channel c become 0.
- R7: In direct mode, `irq_req[k]` is 1 exactly when some channel has enable k set, whatever the state of the flags.
- R8: In direct mode, host reads do not change any enable. A request is held until an enable write clears it.
- R9: When several channels assert the same kind, the matching `irq_req` line is their OR, and it stays high until all of them have dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high LPC reset |
| direct_mode | input | 1 | 0: linked clearing, 1: direct (enable-only) requests |
| odr_fw_wr | input | NUM_CH | Firmware load of output data register or last two-way byte, one bit per channel |
| odr_host_rd | input | NUM_CH | Host read of output data register or last two-way byte, one bit per channel |
| en_wr | input | NUM_CH | Enable word write strobe, one bit per channel |
| en_wdata | input | 7 | Enable word written to every strobed channel, one bit per kind |
| obf | output | NUM_CH | Output-buffer-full flag per channel |
| irq_req | output | 7 | Host interrupt request per kind, OR over the channels |

## Verification
The hardest situation to reach is a host read that empties a channel in the same cycle as a firmware enable write to that channel, or in the same cycle as a fresh output-data load. Only these collisions show which update wins. The stimulus table sets up a full buffer with live enables and then drives both strobes in one row. Later rows confirm from the request lines that the enables were wiped. A second read on an already empty channel, again paired with an enable write, shows that no wipe happens without a real full-to-empty transition. Further rows toggle the mode without touching the enables, so the same stored state can be seen under both request rules.

// File: rtl/lpc_hirq_pkg.sv
`timescale 1ns/1ps
package lpc_hirq_pkg;

    localparam int NUM_KINDS = 7;

    // Kind bit positions (shared by enable words and request lines)
    localparam int K_SMI   = 0;
    localparam int K_IRQ1  = 1;
    localparam int K_IRQ6  = 2;
    localparam int K_IRQ9  = 3;
    localparam int K_IRQ10 = 4;
    localparam int K_IRQ11 = 5;
    localparam int K_IRQ12 = 6;

    typedef logic [NUM_KINDS-1:0] kind_vec_t;

    // Per-channel strobes gathered into one record
    typedef struct packed {
        logic fw_load;   // firmware filled the output buffer
        logic host_read; // host emptied the output buffer
        logic en_write;  // firmware writes the enable word
    } chan_cmd_t;

    // Which kinds a given channel index may raise
    function automatic kind_vec_t allowed_kinds(input int ch_idx);
        kind_vec_t m;
        m = '0;
        if (ch_idx == 0) begin
            m[K_IRQ1]  = 1'b1;
            m[K_IRQ12] = 1'b1;
        end else begin
            m[K_SMI]   = 1'b1;
            m[K_IRQ6]  = 1'b1;
            m[K_IRQ9]  = 1'b1;
            m[K_IRQ10] = 1'b1;
            m[K_IRQ11] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lpc_hirq_chan.sv
`timescale 1ns/1ps
module lpc_hirq_chan
    import lpc_hirq_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      direct_mode,
    input  chan_cmd_t cmd,
    input  kind_vec_t en_wdata,
    output logic      obf_q,
    output kind_vec_t en_q,
    output kind_vec_t req
);

    localparam kind_vec_t ALLOWED = allowed_kinds(CH_IDX);

    logic empty_evt;   // a real full-to-empty host read
    logic wipe_en;

    assign empty_evt = cmd.host_read & obf_q;
    assign wipe_en   = empty_evt & ~direct_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            obf_q <= 1'b0;
        end else if (cmd.fw_load) begin
            obf_q <= 1'b1;
        end else if (cmd.host_read) begin
            obf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wipe_en) begin
            en_q <= '0;
        end else if (cmd.en_write) begin
            en_q <= en_wdata & ALLOWED;
        end
    end

    assign req = en_q & {NUM_KINDS{direct_mode | obf_q}};

endmodule

// File: rtl/lpc_hirq_merge.sv
`timescale 1ns/1ps
module lpc_hirq_merge
    import lpc_hirq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  kind_vec_t [NUM_CH-1:0] ch_req,
    output kind_vec_t              irq_req
);

    kind_vec_t [NUM_CH:0] acc;

    assign acc[0] = '0;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_or
        assign acc[c+1] = acc[c] | ch_req[c];
    end

    assign irq_req = acc[NUM_CH];

endmodule

// File: rtl/lpc_hirq_ctrl.sv
`timescale 1ns/1ps
module lpc_hirq_ctrl
    import lpc_hirq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 direct_mode,
    input  logic [NUM_CH-1:0]    odr_fw_wr,
    input  logic [NUM_CH-1:0]    odr_host_rd,
    input  logic [NUM_CH-1:0]    en_wr,
    input  logic [NUM_KINDS-1:0] en_wdata,
    output logic [NUM_CH-1:0]    obf,
    output logic [NUM_KINDS-1:0] irq_req
);

    chan_cmd_t [NUM_CH-1:0] cmd;
    kind_vec_t [NUM_CH-1:0] ch_en;
    kind_vec_t [NUM_CH-1:0] ch_req;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign cmd[c] = '{fw_load: odr_fw_wr[c],
                          host_read: odr_host_rd[c],
                          en_write: en_wr[c]};

        lpc_hirq_chan #(.CH_IDX(c)) u_chan (
            .clk         (clk),
            .rst         (rst),
            .direct_mode (direct_mode),
            .cmd         (cmd[c]),
            .en_wdata    (en_wdata),
            .obf_q       (obf[c]),
            .en_q        (ch_en[c]),
            .req         (ch_req[c])
        );
    end

    lpc_hirq_merge #(.NUM_CH(NUM_CH)) u_merge (
        .ch_req  (ch_req),
        .irq_req (irq_req)
    );

endmodule

// File: rtl/lpc_hirq_chk.sv
`timescale 1ns/1ps
module lpc_hirq_chk
    import lpc_hirq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   direct_mode,
    input logic [NUM_CH-1:0]      odr_fw_wr,
    input logic [NUM_CH-1:0]      odr_host_rd,
    input logic [NUM_CH-1:0]      en_wr,
    input logic [NUM_CH-1:0]      obf,
    input logic [NUM_KINDS-1:0]   irq_req,
    input kind_vec_t [NUM_CH-1:0] ch_en
);

    // R1: reset leaves flags and requests empty
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (obf == '0 && irq_req == '0));

    // R2: a firmware load always leaves the flag set
    p_load_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (odr_fw_wr != '0) |=> ((obf & $past(odr_fw_wr)) == $past(odr_fw_wr)));

    // R2: a lone host read always leaves the flag empty
    p_read_clears_r2: assert property (@(posedge clk) disable iff (rst)
        ((odr_host_rd & ~odr_fw_wr) != '0)
        |=> ((obf & $past(odr_host_rd & ~odr_fw_wr)) == '0));

    // R4: linked mode with every buffer empty raises nothing
    p_linked_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!direct_mode && obf == '0) |-> (irq_req == '0));

    // R8: in direct mode, requests only move on enable writes
    p_direct_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (direct_mode && en_wr == '0) |=> (!direct_mode || $stable(irq_req)));

    // R5, R6: a linked full-to-empty read wipes the channel enables
    for (genvar c = 0; c < NUM_CH; c++) begin : g_wipe
        p_wipe_on_empty_r5: assert property (@(posedge clk) disable iff (rst)
            (!direct_mode && odr_host_rd[c] && obf[c]) |=> (ch_en[c] == '0));
    end

endmodule

bind lpc_hirq_ctrl lpc_hirq_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .direct_mode (direct_mode),
    .odr_fw_wr   (odr_fw_wr),
    .odr_host_rd (odr_host_rd),
    .en_wr       (en_wr),
    .obf         (obf),
    .irq_req     (irq_req),
    .ch_en       (ch_en)
);

// File: tb/tb_lpc_hirq_ctrl.sv
`timescale 1ns/1ps
module tb_lpc_hirq_ctrl;

    localparam int NCH = 4;
    localparam int NK  = 7;
    localparam int NV  = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic direct_mode = 1'b0;
    logic [NCH-1:0] odr_fw_wr = '0;
    logic [NCH-1:0] odr_host_rd = '0;
    logic [NCH-1:0] en_wr = '0;
    logic [NK-1:0]  en_wdata = '0;
    logic [NCH-1:0] obf;
    logic [NK-1:0]  irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    lpc_hirq_ctrl #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst(rst), .direct_mode(direct_mode),
        .odr_fw_wr(odr_fw_wr), .odr_host_rd(odr_host_rd),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .obf(obf), .irq_req(irq_req)
    );

    // Row: {req tag, mode, fw load, host read, en write, en data, exp req, exp obf}
    // Kinds: SMI=01 IRQ1=02 IRQ6=04 IRQ9=08 IRQ10=10 IRQ11=20 IRQ12=40
    localparam logic [34:0] VEC [0:NV-1] = '{
        {4'd4, 1'b0, 4'h0, 4'h0, 4'h1, 7'h7F, 7'h00, 4'h0}, // R4 ch0 en, empty
        {4'd2, 1'b0, 4'h1, 4'h0, 4'h0, 7'h00, 7'h42, 4'h1}, // R2 load ch0
        {4'd4, 1'b0, 4'h0, 4'h0, 4'h2, 7'h7F, 7'h42, 4'h1}, // R4 ch1 en, empty
        {4'd9, 1'b0, 4'h2, 4'h0, 4'h0, 7'h00, 7'h7F, 4'h3}, // R9 two channels
        {4'd5, 1'b0, 4'h0, 4'h1, 4'h0, 7'h00, 7'h3D, 4'h2}, // R5 read ch0 wipes
        {4'd5, 1'b0, 4'h1, 4'h0, 4'h0, 7'h00, 7'h3D, 4'h3}, // R5 refill, stays off
        {4'd6, 1'b0, 4'h0, 4'h2, 4'h2, 7'h04, 7'h00, 4'h1}, // R6 wipe beats write
        {4'd5, 1'b0, 4'h0, 4'h2, 4'h2, 7'h04, 7'h00, 4'h1}, // R5 empty read no wipe
        {4'd7, 1'b1, 4'h0, 4'h0, 4'h0, 7'h00, 7'h04, 4'h1}, // R7 direct shows en
        {4'd7, 1'b1, 4'h0, 4'h0, 4'h4, 7'h08, 7'h0C, 4'h1}, // R7 ch2 en
        {4'd2, 1'b1, 4'h4, 4'h0, 4'h0, 7'h00, 7'h0C, 4'h5}, // R2 load ch2
        {4'd8, 1'b1, 4'h0, 4'h4, 4'h0, 7'h00, 7'h0C, 4'h1}, // R8 read keeps en
        {4'd3, 1'b1, 4'h0, 4'h0, 4'h8, 7'h42, 7'h0C, 4'h1}, // R3 ch3 drops 42
        {4'd3, 1'b1, 4'h0, 4'h0, 4'h1, 7'h3D, 7'h0C, 4'h1}, // R3 ch0 drops 3D
        {4'd3, 1'b1, 4'h0, 4'h0, 4'h1, 7'h40, 7'h4C, 4'h1}, // R3 ch0 IRQ12
        {4'd2, 1'b1, 4'h1, 4'h1, 4'h0, 7'h00, 7'h4C, 4'h1}, // R2 load beats read
        {4'd4, 1'b0, 4'h0, 4'h0, 4'h0, 7'h00, 7'h40, 4'h1}, // R4 back to linked
        {4'd5, 1'b0, 4'h1, 4'h1, 4'h0, 7'h00, 7'h00, 4'h1}, // R5 load+read wipes
        {4'd9, 1'b0, 4'h2, 4'h0, 4'h6, 7'h3D, 7'h3D, 4'h3}, // R9 ch1 and ch2
        {4'd9, 1'b0, 4'h0, 4'h0, 4'h2, 7'h00, 7'h00, 4'h3}, // R9 ch2 still empty
        {4'd4, 1'b0, 4'h4, 4'h0, 4'h0, 7'h00, 7'h3D, 4'h7}, // R4 ch2 full
        {4'd8, 1'b1, 4'h0, 4'h0, 4'h4, 7'h00, 7'h00, 4'h7}  // R8 write clears
    };

    task automatic check(input string tag, input int row,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s row %0d: actual %h expected %h", tag, row, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic idle_inputs();
        odr_fw_wr   = '0;
        odr_host_rd = '0;
        en_wr       = '0;
        en_wdata    = '0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        check("R1 obf", -1, 32'(obf), 32'h0);
        check("R1 irq_req", -1, 32'(irq_req), 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tg;
            @(negedge clk);
            tg = $sformatf("R%0d", VEC[i][34:31]);
            direct_mode = VEC[i][30];
            odr_fw_wr   = VEC[i][29:26];
            odr_host_rd = VEC[i][25:22];
            en_wr       = VEC[i][21:18];
            en_wdata    = VEC[i][17:11];
            @(posedge clk);
            #1;
            idle_inputs();
            check({tg, " irq_req"}, i, 32'(irq_req), 32'(VEC[i][10:4]));
            check({tg, " obf"}, i, 32'(obf), 32'(VEC[i][3:0]));
        end

        // R1: reset mid-run with a load pending and enables live
        @(negedge clk);
        direct_mode = 1'b1;
        en_wr = 4'h3; en_wdata = 7'h7F;
        @(posedge clk); #1;
        idle_inputs();
        check("R1 pre-reset req", 100, 32'(irq_req), 32'h7F);
        @(negedge clk);
        rst = 1'b1;
        odr_fw_wr = 4'hF;
        @(posedge clk); #1;
        check("R1 obf in reset", 101, 32'(obf), 32'h0);
        check("R1 irq_req in reset", 101, 32'(irq_req), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        idle_inputs();
        @(posedge clk); #1;
        // direct mode shows raw enables: all must be gone
        check("R1 enables cleared", 102, 32'(irq_req), 32'h0);

        // R7: direct mode, request with every flag empty, then R8 hold
        @(negedge clk);
        en_wr = 4'h8; en_wdata = 7'h20;
        @(posedge clk); #1;
        idle_inputs();
        check("R7 direct empty", 103, 32'(irq_req), 32'h20);
        @(negedge clk);
        odr_fw_wr = 4'h8;
        @(posedge clk); #1;
        idle_inputs();
        @(negedge clk);
        odr_host_rd = 4'h8;
        @(posedge clk); #1;
        idle_inputs();
        check("R8 held after read", 104, 32'(irq_req), 32'h20);
        check("R2 read empties", 104, 32'(obf), 32'h0);

        @(negedge clk);
        finish_run();
    end

endmodule